// File: doc/BRIEF.md
# Universal registered bus transceiver

This block carries data between two 18-bit buses, called the A side and the B side. The two directions work on their own. Each direction has one storage stage, and four controls pick how that stage behaves. When the pass-through control is high, the stage is transparent and the output follows the input. When it is low, the stage holds its value. While it holds, the stage can take a new word on a rising edge of that direction's own data clock, provided the clock enable is low. The output enable is active low. It decides whether the direction drives its side of the bus. Three-state behaviour is shown as a data vector plus a drive flag for each side.

All storage runs on one free-running system clock. Each direction's data clock is an asynchronous input. It is passed through a synchroniser, and its rising edge becomes a one-cycle load strobe. The input word and the clock enable pass through a delay line of the same length. A capture therefore takes the word and the enable level from the system clock edge at which the direction clock was first seen high. The pass-through path is a combinational bypass around the storage register. While the path is open, the register follows the input, so the output does not move when the path closes.

Top module: `brx_xcvr`

## Requirements
- R1: The two directions are independent, and each is WIDTH bits wide (default 18). A-to-B takes `a_in` to `b_out`. B-to-A takes `b_in` to `a_out`. No control of one direction changes the other direction's output.
- R2: While a direction's pass control (`*_le`) is high, its output data equals its input data in the same cycle.
- R3: While the pass control is low and the direction clock shows no new rising edge, the output data keeps its value, whatever the input data does.
- R4: With the pass control low and the clock enable (`*_cken_n`) low, a rising edge of the direction clock captures the input word. The captured word is the one present at the system clock edge that first samples the direction clock high. It appears on the output SYNC_STAGES system clock edges after that edge (2 by default).
- R5: If the clock enable is high at the system clock edge that first samples the direction clock high, that rising edge changes nothing.
- R6: When the pass control falls, the output keeps the input value that was present at the last system clock edge with the control high.
- R7: A direction's drive flag is high exactly when its output enable (`*_oe_n`, active low) is low and reset is not active. The output enables are used so that at most one side drives at any time.
- R8: A synchronous, active-high reset clears both stored words to zero and holds both drive flags low.
- R9: When a capture and an open pass control land on the same system clock edge, the pass control wins, and the register takes the current input word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running system clock |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | WIDTH | Word received from the A bus |
| b_in | input | WIDTH | Word received from the B bus |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B pass control, high = transparent |
| ab_clk | input | 1 | A-to-B data clock, asynchronous |
| ab_cken_n | input | 1 | A-to-B clock enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A pass control, high = transparent |
| ba_clk | input | 1 | B-to-A data clock, asynchronous |
| ba_cken_n | input | 1 | B-to-A clock enable, active low |
| b_out | output | WIDTH | Word presented to the B bus |
| b_drive | output | 1 | B bus driven when high, released when low |
| a_out | output | WIDTH | Word presented to the A bus |
| a_drive | output | 1 | A bus driven when high, released when low |

## Verification
The hardest case to reach from the ports is a capture strobe that lands on the same system clock edge where the pass control is still high. Only that case separates the priority in R9 from a design where the capture wins. To reach it, the stimulus raises the direction clock together with the pass control, changes the input word on the next cycle, and then drops the pass control right after the synchroniser delay has run out. The capture edge is the last edge with the path open. A second hard case is the edge that arrives while the clock enable is high. It is reached by holding the enable high exactly at the first sampled high level of the direction clock.

// File: rtl/brx_pkg.sv
package brx_pkg;

  localparam int unsigned DIRS = 2;

  typedef struct packed {
    logic oe_n;
    logic le;
    logic dclk;
    logic cken_n;
  } dir_ctl_t;

endpackage

// File: rtl/brx_edge_sync.sv
module brx_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);

  logic [STAGES-1:0] sync_q;
  logic              last_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q[0] <= async_in;
      for (int i = 1; i < STAGES; i++) begin
        sync_q[i] <= sync_q[i-1];
      end
      last_q <= sync_q[STAGES-1];
    end
  end

  assign rise = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/brx_delay.sv
module brx_delay #(
  parameter int unsigned WIDTH  = 19,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    stage_q[0] <= din;
    for (int i = 1; i < STAGES; i++) begin
      stage_q[i] <= stage_q[i-1];
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/brx_lane.sv
module brx_lane
  import brx_pkg::*;
#(
  parameter int unsigned WIDTH  = 18,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  input  dir_ctl_t         ctl,
  output logic [WIDTH-1:0] dout,
  output logic             drive
);

  localparam int unsigned PW = WIDTH + 1;

  logic             rise;
  logic [PW-1:0]    dly;
  logic [WIDTH-1:0] store_q;

  brx_edge_sync #(.STAGES(STAGES)) u_edge (
    .clk      (clk),
    .rst      (rst),
    .async_in (ctl.dclk),
    .rise     (rise)
  );

  brx_delay #(.WIDTH(PW), .STAGES(STAGES)) u_dly (
    .clk  (clk),
    .din  ({ctl.cken_n, din}),
    .dout (dly)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      store_q <= '0;
    end else if (ctl.le) begin
      store_q <= din;
    end else if (rise && !dly[PW-1]) begin
      store_q <= dly[WIDTH-1:0];
    end
  end

  assign dout  = ctl.le ? din : store_q;
  assign drive = !ctl.oe_n && !rst;

endmodule

// File: rtl/brx_xcvr.sv
module brx_xcvr
  import brx_pkg::*;
#(
  parameter int unsigned WIDTH       = 18,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] a_in,
  input  logic [WIDTH-1:0] b_in,
  input  logic             ab_oe_n,
  input  logic             ab_le,
  input  logic             ab_clk,
  input  logic             ab_cken_n,
  input  logic             ba_oe_n,
  input  logic             ba_le,
  input  logic             ba_clk,
  input  logic             ba_cken_n,
  output logic [WIDTH-1:0] b_out,
  output logic             b_drive,
  output logic [WIDTH-1:0] a_out,
  output logic             a_drive
);

  logic [WIDTH-1:0] lane_din  [DIRS];
  dir_ctl_t         lane_ctl  [DIRS];
  logic [WIDTH-1:0] lane_dout [DIRS];
  logic             lane_drv  [DIRS];

  assign lane_din[0] = a_in;
  assign lane_din[1] = b_in;
  assign lane_ctl[0] = {ab_oe_n, ab_le, ab_clk, ab_cken_n};
  assign lane_ctl[1] = {ba_oe_n, ba_le, ba_clk, ba_cken_n};

  for (genvar d = 0; d < DIRS; d++) begin : g_dir
    brx_lane #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_lane (
      .clk   (clk),
      .rst   (rst),
      .din   (lane_din[d]),
      .ctl   (lane_ctl[d]),
      .dout  (lane_dout[d]),
      .drive (lane_drv[d])
    );
  end

  assign b_out   = lane_dout[0];
  assign b_drive = lane_drv[0];
  assign a_out   = lane_dout[1];
  assign a_drive = lane_drv[1];

endmodule

// File: rtl/brx_xcvr_chk.sv
module brx_xcvr_chk #(
  parameter int unsigned WIDTH       = 18,
  parameter int unsigned SYNC_STAGES = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] b_in,
  input logic             ab_le,
  input logic             ab_clk,
  input logic             ba_le,
  input logic             ba_clk,
  input logic [WIDTH-1:0] b_out,
  input logic             b_drive,
  input logic [WIDTH-1:0] a_out,
  input logic             a_drive
);

  localparam logic [7:0] QUIET_MIN = 8'(SYNC_STAGES + 2);

  logic [7:0] ab_quiet, ba_quiet;
  logic       ab_ck_q, ba_ck_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ab_quiet <= '0;
      ba_quiet <= '0;
    end else begin
      if (ab_clk != ab_ck_q) ab_quiet <= '0;
      else if (ab_quiet != 8'hff) ab_quiet <= ab_quiet + 8'd1;
      if (ba_clk != ba_ck_q) ba_quiet <= '0;
      else if (ba_quiet != 8'hff) ba_quiet <= ba_quiet + 8'd1;
    end
    ab_ck_q <= ab_clk;
    ba_ck_q <= ba_clk;
  end

  AST_AB_CLOSE_KEEPS: assert property (@(posedge clk) disable iff (rst) ($fell(ab_le) && !$past(rst)) |-> (b_out == $past(a_in))); // R6
  AST_BA_CLOSE_KEEPS: assert property (@(posedge clk) disable iff (rst) ($fell(ba_le) && !$past(rst)) |-> (a_out == $past(b_in))); // R6
  AST_AB_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) (ab_quiet >= QUIET_MIN && !ab_le && !$past(ab_le) && !$past(rst)) |-> $stable(b_out)); // R3
  AST_BA_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst) (ba_quiet >= QUIET_MIN && !ba_le && !$past(ba_le) && !$past(rst)) |-> $stable(a_out)); // R3
  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst) ($past(rst) && !ab_le && !ba_le) |-> (b_out == '0 && a_out == '0)); // R8
  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst) !(a_drive && b_drive)); // R7

endmodule

bind brx_xcvr brx_xcvr_chk #(.WIDTH(WIDTH), .SYNC_STAGES(SYNC_STAGES)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .a_in    (a_in),
  .b_in    (b_in),
  .ab_le   (ab_le),
  .ab_clk  (ab_clk),
  .ba_le   (ba_le),
  .ba_clk  (ba_clk),
  .b_out   (b_out),
  .b_drive (b_drive),
  .a_out   (a_out),
  .a_drive (a_drive)
);

// File: tb/brx_xcvr_bench.sv
`timescale 1ns/1ps
module brx_xcvr_bench;
  localparam int W  = 18;
  localparam int S  = 2;
  localparam int HD = S + 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [W-1:0] din_v [2];
  logic oe_v [2];
  logic le_v [2];
  logic ck_v [2];
  logic ce_v [2];
  logic [W-1:0] b_out_w, a_out_w;
  logic b_drv_w, a_drv_w;

  brx_xcvr #(.WIDTH(W), .SYNC_STAGES(S)) u_brx_xcvr (
    .clk(clk), .rst(rst), .a_in(din_v[0]), .b_in(din_v[1]),
    .ab_oe_n(oe_v[0]), .ab_le(le_v[0]), .ab_clk(ck_v[0]), .ab_cken_n(ce_v[0]),
    .ba_oe_n(oe_v[1]), .ba_le(le_v[1]), .ba_clk(ck_v[1]), .ba_cken_n(ce_v[1]),
    .b_out(b_out_w), .b_drive(b_drv_w), .a_out(a_out_w), .a_drive(a_drv_w)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit run = 1'b0;

  function automatic logic [W-1:0] out_of(input int d);
    return (d == 0) ? b_out_w : a_out_w;
  endfunction

  function automatic logic drv_of(input int d);
    return (d == 0) ? b_drv_w : a_drv_w;
  endfunction

  task automatic check(input string tag, input logic [W-1:0] got, input logic [W-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: got %h expected %h", tag, $time, got, exp);
    end
  endtask

  // behavioural reference: history of sampled inputs per direction
  logic [W-1:0] m_store [2];
  logic         h_ck [2][HD];
  logic         h_ce [2][HD];
  logic [W-1:0] h_d  [2][HD];
  logic         m_le_prev [2];
  string        m_tag [2];

  always @(posedge clk) begin
    for (int d = 0; d < 2; d++) begin
      if (rst) begin
        m_store[d] = '0;
        m_tag[d] = "R8";
        for (int i = 0; i < HD; i++) begin
          h_ck[d][i] = 1'b0; h_ce[d][i] = 1'b1; h_d[d][i] = '0;
        end
      end else begin
        if (le_v[d]) begin
          m_store[d] = din_v[d];
          m_tag[d] = "R2";
        end else if (h_ck[d][S-1] && !h_ck[d][S]) begin
          if (!h_ce[d][S-1]) begin
            m_store[d] = h_d[d][S-1];
            m_tag[d] = "R4";
          end else m_tag[d] = "R5";
        end else if (m_le_prev[d]) m_tag[d] = "R6";
        else m_tag[d] = "R3";
        for (int i = HD - 1; i > 0; i--) begin
          h_ck[d][i] = h_ck[d][i-1]; h_ce[d][i] = h_ce[d][i-1]; h_d[d][i] = h_d[d][i-1];
        end
        h_ck[d][0] = ck_v[d]; h_ce[d][0] = ce_v[d]; h_d[d][0] = din_v[d];
      end
      m_le_prev[d] = le_v[d];
    end
  end

  always @(negedge clk) begin
    if (run) begin
      for (int d = 0; d < 2; d++) begin
        check(le_v[d] ? "R2" : m_tag[d], out_of(d), le_v[d] ? din_v[d] : m_store[d]);
        check("R7", W'(drv_of(d)), W'(!oe_v[d] && !rst));
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    for (int d = 0; d < 2; d++) begin
      din_v[d] = '0; oe_v[d] = 1'b1; le_v[d] = 1'b0; ck_v[d] = 1'b0; ce_v[d] = 1'b1;
    end
    tick(1);
    run = 1'b1;
    oe_v[0] = 1'b0;
    tick(3);
    @(negedge clk);
    check("R7", W'(b_drv_w), W'(1'b0));
    check("R7", W'(a_drv_w), W'(1'b0));
    tick(1);
    rst = 1'b0;
    oe_v[0] = 1'b1;
    @(negedge clk);
    check("R8", b_out_w, '0);
    check("R8", a_out_w, '0);

    // transparency, and independence of the other direction
    tick(1);
    le_v[0] = 1'b1; din_v[0] = 18'h2a5c3; oe_v[0] = 1'b0;
    din_v[1] = 18'h1ffff;
    @(negedge clk);
    check("R2", b_out_w, 18'h2a5c3);
    check("R1", a_out_w, '0);
    check("R7", W'(b_drv_w), W'(1'b1));
    tick(1);
    din_v[0] = 18'h0f0f1;
    @(negedge clk);
    check("R2", b_out_w, 18'h0f0f1);

    // closing the pass path keeps the last passed word
    tick(1);
    le_v[0] = 1'b0; din_v[0] = 18'h33333;
    @(negedge clk);
    check("R6", b_out_w, 18'h0f0f1);

    // enabled capture, timed through the synchroniser
    tick(1);
    ce_v[0] = 1'b0; ck_v[0] = 1'b1; din_v[0] = 18'h12345;
    tick(S);
    @(negedge clk);
    check("R4", b_out_w, 18'h0f0f1);
    tick(1);
    @(negedge clk);
    check("R4", b_out_w, 18'h12345);
    tick(1);
    din_v[0] = 18'h3c3c3;
    tick(4);
    @(negedge clk);
    check("R3", b_out_w, 18'h12345);

    // edge with clock enable high is ignored
    ck_v[0] = 1'b0;
    tick(4);
    ce_v[0] = 1'b1; ck_v[0] = 1'b1; din_v[0] = 18'h0aaaa;
    tick(5);
    @(negedge clk);
    check("R5", b_out_w, 18'h12345);
    ck_v[0] = 1'b0; din_v[0] = 18'h15555;
    tick(5);
    @(negedge clk);
    check("R3", b_out_w, 18'h12345);

    // pass control open on the capture edge wins
    ce_v[0] = 1'b0; le_v[0] = 1'b1; ck_v[0] = 1'b1; din_v[0] = 18'h2dead;
    tick(1);
    din_v[0] = 18'h1beef;
    tick(S);
    le_v[0] = 1'b0; din_v[0] = 18'h00001;
    @(negedge clk);
    check("R9", b_out_w, 18'h1beef);

    // reverse direction
    ck_v[0] = 1'b0; ce_v[0] = 1'b1;
    oe_v[0] = 1'b1; oe_v[1] = 1'b0;
    ce_v[1] = 1'b0; ck_v[1] = 1'b1; din_v[1] = 18'h2468a;
    tick(S + 1);
    @(negedge clk);
    check("R4", a_out_w, 18'h2468a);
    check("R7", W'(a_drv_w), W'(1'b1));
    check("R7", W'(b_drv_w), W'(1'b0));
    check("R1", b_out_w, 18'h1beef);
    oe_v[1] = 1'b1;
    tick(1);
    @(negedge clk);
    check("R7", W'(a_drv_w), W'(1'b0));
    check("R7", a_out_w, 18'h2468a);

    // mixed traffic, one driver at most
    for (int c = 0; c < 3000; c++) begin
      tick(1);
      for (int d = 0; d < 2; d++) begin
        din_v[d] = W'($urandom);
        le_v[d] = ($urandom % 8) == 0;
        if (($urandom % 3) == 0) ck_v[d] = ~ck_v[d];
        ce_v[d] = ($urandom % 4) == 0;
      end
      begin
        int r;
        r = int'($urandom % 3);
        oe_v[0] = (r != 0);
        oe_v[1] = (r != 1);
      end
    end
    tick(2);
    finish_run();
  end

endmodule